// File: doc/BRIEF.md
# Multiplexed Column Drive Modulator

This block refreshes a row of eight 5x7 dot-matrix character cells. It splits the cells into two groups of four digits and scans fourteen row slots. Each slot lights one glyph row of one group and presents twenty column lines, which are five columns for each of four digits. For every slot it reads the stored character entries. It sends each entry either to an external character ROM lookup port or to an external custom-glyph RAM lookup port, and places the returned row patterns on the column lines.

Three modifiers gate the column drive. A brightness code shortens the part of each slot during which columns are driven, and leaves the peak level alone. A per-digit flash turns off the selected digits during the off half of a slow toggle. A display-wide blink turns off every column during that same off half. The block runs either from its internal clock, which it also passes out for chaining, or from an external clock input.

Top module: `colmod_top`

## Requirements
- R1: While reset is held and in the cycles before scanning starts, `row_en` is 14'h0001, `col_drive` is zero and the toggle is in its on half.
- R2: Each slot lasts 9 core clocks. `row_en` is one-hot, and its set bit steps 0,1,...,13 and then wraps to 0. Bit k lights glyph row k>>1 of group k&1. Group 0 holds digits 0-3 and group 1 holds digits 4-7. Scanning starts on the third core clock edge after `rst_n` rises.
- R3: On the first clock of every slot, which is the clock on which `row_en` changes, every column is off.
- R4: Let code = `ctrl_word[2:0]` and on = 8 when code is 0, else 7-code. Clock j (1..8) of a slot drives the columns only if j <= on. The peak value is the unmodified glyph bit.
- R5: Lane l carries digit 4g+l on `col_drive[5l+4:5l]`, with glyph column c on bit 5l+c. An entry with bit 7 clear puts bits 6:0 on the lane's `rom_code` field and shows `rom_pattern`. An entry with bit 7 set puts bits 3:0 on `udc_addr` and shows `udc_pattern`. `glyph_row` carries the current glyph row.
- R6: The toggle holds each half for HALF_PERIOD core clocks. It starts in the on half when scanning starts.
- R7: When `ctrl_word[3]` is 1, each digit whose `flash_bits` bit is set is dark during the off half, and the other digits are unaffected. When `ctrl_word[3]` is 0, `flash_bits` has no effect.
- R8: When `ctrl_word[4]` is 1, all twenty columns are off during the off half.
- R9: With `clk_sel`=1 the block runs on `int_clk` and `clk_out` follows `int_clk`. With `clk_sel`=0 it runs on `ext_clk` and `clk_out` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal oscillator clock |
| ext_clk | input | 1 | External clock from a chained unit |
| clk_sel | input | 1 | 1 selects int_clk, 0 selects ext_clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_entries | input | 64 | Eight character entries, digit d at bits 8d+7:8d |
| flash_bits | input | 8 | Per-digit flash select |
| ctrl_word | input | 5 | [2:0] brightness code, [3] flash enable, [4] blink enable |
| rom_code | output | 28 | Four 7-bit character codes, lane l at bits 7l+6:7l |
| udc_addr | output | 16 | Four 4-bit custom-glyph addresses |
| glyph_row | output | 3 | Glyph row being fetched |
| rom_pattern | input | 20 | Character ROM row patterns, 5 bits per lane |
| udc_pattern | input | 20 | Custom-glyph RAM row patterns, 5 bits per lane |
| row_en | output | 14 | One-hot row enables in scan order |
| col_drive | output | 20 | Column drive lines |
| clk_out | output | 1 | Internal clock output for chaining |

## Verification
Some behaviours are checked on every core clock. These are the one-hot row enable and its fixed stepping order, the dark columns on every row change, the dark display at the lowest brightness code, the blanking of all columns during the blink off half, and the idle clock output under external clocking. Other behaviours can only be shown by the bench's scenarios, which compare every cycle against an independent model. These include the exact duty window for each brightness level, the choice between the ROM and the custom-glyph path, the per-digit flash mask and its inertness when flash is disabled, the toggle period, and the switch to the external clock.

// File: rtl/colmod_pkg.sv
package colmod_pkg;
  localparam int DIGITS     = 8;
  localparam int LANES      = 4;
  localparam int GROUPS     = DIGITS / LANES;
  localparam int GLYPH_COLS = 5;
  localparam int GLYPH_ROWS = 7;
  localparam int SLOTS      = GLYPH_ROWS * GROUPS;
  localparam int COLS       = LANES * GLYPH_COLS;
  localparam int ENTRY_W    = 8;
  localparam int CODE_W     = 7;
  localparam int UDC_AW     = 4;
  localparam int ROW_W      = $clog2(GLYPH_ROWS);
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int BRIGHT_W   = 3;
  localparam int CW_FLASH   = BRIGHT_W;
  localparam int CW_BLINK   = BRIGHT_W + 1;
  localparam int CW_W       = BRIGHT_W + 2;
  localparam int DUTY_STEPS = 1 << BRIGHT_W;

  typedef logic [ENTRY_W-1:0] char_entry_t;
endpackage

// File: rtl/colmod_clk_rst.sv
module colmod_clk_rst (
  input  logic int_clk,
  input  logic ext_clk,
  input  logic clk_sel,
  input  logic rst_n,
  output logic core_clk,
  output logic clk_out,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  // static source select; clk_sel is only changed while the block is held in reset
  assign core_clk = clk_sel ? int_clk : ext_clk;
  assign clk_out  = clk_sel & int_clk;

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/colmod_scan.sv
module colmod_scan
  import colmod_pkg::*;
#(
  parameter int SLOT_TICKS = DUTY_STEPS + 1,
  localparam int TICK_W = $clog2(SLOT_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick,
  output logic [SLOT_W-1:0] slot
);
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              slot_end;

  assign slot_end = (tick_q == TICK_W'(SLOT_TICKS - 1));

  always_comb begin
    tick_d = tick_q + 1'b1;
    slot_d = slot_q;
    if (slot_end) begin
      tick_d = '0;
      slot_d = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      slot_q <= '0;
    end else begin
      tick_q <= tick_d;
      slot_q <= slot_d;
    end
  end

  assign tick = tick_q;
  assign slot = slot_q;
endmodule

// File: rtl/colmod_toggle.sv
module colmod_toggle #(
  parameter int unsigned HALF_PERIOD = 25_000_000,
  localparam int CNT_W = $clog2(HALF_PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  output logic on_phase
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(HALF_PERIOD - 1));

  always_comb begin
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign on_phase = phase_q;
endmodule

// File: rtl/colmod_lane.sv
module colmod_lane
  import colmod_pkg::*;
(
  input  char_entry_t            entry,
  input  logic                   flash_bit,
  input  logic                   flash_dark,
  input  logic [GLYPH_COLS-1:0]  rom_pat,
  input  logic [GLYPH_COLS-1:0]  udc_pat,
  output logic [CODE_W-1:0]      code,
  output logic [UDC_AW-1:0]      udc_a,
  output logic [GLYPH_COLS-1:0]  pat_out
);
  logic is_custom;
  logic [GLYPH_COLS-1:0] picked;

  assign is_custom = entry[ENTRY_W-1];
  assign code      = entry[CODE_W-1:0];
  assign udc_a     = entry[UDC_AW-1:0];

  always_comb begin
    picked  = is_custom ? udc_pat : rom_pat;
    pat_out = (flash_bit && flash_dark) ? '0 : picked;
  end
endmodule

// File: rtl/colmod_top.sv
module colmod_top
  import colmod_pkg::*;
#(
  parameter int unsigned HALF_PERIOD = 25_000_000,
  localparam int SLOT_TICKS = DUTY_STEPS + 1,
  localparam int TICK_W     = $clog2(SLOT_TICKS)
) (
  input  logic                        int_clk,
  input  logic                        ext_clk,
  input  logic                        clk_sel,
  input  logic                        rst_n,
  input  logic [DIGITS*ENTRY_W-1:0]   char_entries,
  input  logic [DIGITS-1:0]           flash_bits,
  input  logic [CW_W-1:0]             ctrl_word,
  output logic [LANES*CODE_W-1:0]     rom_code,
  output logic [LANES*UDC_AW-1:0]     udc_addr,
  output logic [ROW_W-1:0]            glyph_row,
  input  logic [COLS-1:0]             rom_pattern,
  input  logic [COLS-1:0]             udc_pattern,
  output logic [SLOTS-1:0]            row_en,
  output logic [COLS-1:0]             col_drive,
  output logic                        clk_out
);
  logic                core_clk;
  logic                rst_core_n;
  logic [TICK_W-1:0]   tick;
  logic [SLOT_W-1:0]   slot;
  logic                blink_phase;
  logic                group;
  logic                flash_dark;
  logic                blink_dark;
  logic [BRIGHT_W-1:0] bright_code;
  logic [TICK_W-1:0]   on_ticks;
  logic                drive_window;
  logic [COLS-1:0]     lane_cols;

  colmod_clk_rst u_clk_rst (
    .int_clk    (int_clk),
    .ext_clk    (ext_clk),
    .clk_sel    (clk_sel),
    .rst_n      (rst_n),
    .core_clk   (core_clk),
    .clk_out    (clk_out),
    .rst_core_n (rst_core_n)
  );

  colmod_scan #(.SLOT_TICKS(SLOT_TICKS)) u_scan (
    .clk   (core_clk),
    .rst_n (rst_core_n),
    .tick  (tick),
    .slot  (slot)
  );

  colmod_toggle #(.HALF_PERIOD(HALF_PERIOD)) u_toggle (
    .clk      (core_clk),
    .rst_n    (rst_core_n),
    .on_phase (blink_phase)
  );

  // slot index is 2*row + group, so one shift gives the scan-ordered enable
  assign group     = slot[0];
  assign glyph_row = ROW_W'(slot >> 1);
  assign row_en    = SLOTS'(1) << slot;

  assign flash_dark = ctrl_word[CW_FLASH] & ~blink_phase;
  assign blink_dark = ctrl_word[CW_BLINK] & ~blink_phase;

  // brightness: code 0 is full duty, code k>0 keeps 7-k of the 8 phases
  assign bright_code = ctrl_word[BRIGHT_W-1:0];
  always_comb begin
    if (bright_code == '0) on_ticks = TICK_W'(DUTY_STEPS);
    else                   on_ticks = TICK_W'(DUTY_STEPS - 1) - TICK_W'(bright_code);
  end

  // tick 0 is the blanking interval at each row switch
  assign drive_window = (tick != '0) && (tick <= on_ticks);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    char_entry_t entry;
    logic        fbit;

    assign entry = group ? char_entries[(LANES + l)*ENTRY_W +: ENTRY_W]
                         : char_entries[l*ENTRY_W +: ENTRY_W];
    assign fbit  = group ? flash_bits[LANES + l] : flash_bits[l];

    colmod_lane u_lane (
      .entry      (entry),
      .flash_bit  (fbit),
      .flash_dark (flash_dark),
      .rom_pat    (rom_pattern[l*GLYPH_COLS +: GLYPH_COLS]),
      .udc_pat    (udc_pattern[l*GLYPH_COLS +: GLYPH_COLS]),
      .code       (rom_code[l*CODE_W +: CODE_W]),
      .udc_a      (udc_addr[l*UDC_AW +: UDC_AW]),
      .pat_out    (lane_cols[l*GLYPH_COLS +: GLYPH_COLS])
    );
  end

  assign col_drive = (drive_window && !blink_dark) ? lane_cols : '0;
endmodule

// File: rtl/colmod_chk.sv
module colmod_chk
  import colmod_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SLOTS-1:0] row_en,
  input logic [COLS-1:0]  col_drive,
  input logic [CW_W-1:0]  ctrl_word,
  input logic             blink_phase,
  input logic             clk_sel,
  input logic             clk_out
);
  // R2
  onehot_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(row_en) == 1);

  // R2
  row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en != $past(row_en)) |-> (row_en == {$past(row_en[SLOTS-2:0]), $past(row_en[SLOTS-1])}));

  // R3
  switch_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_en != $past(row_en)) |-> (col_drive == '0));

  // R4
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[BRIGHT_W-1:0] == '1) |-> (col_drive == '0));

  // R8
  blink_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[CW_BLINK] && !blink_phase) |-> (col_drive == '0));

  // R9
  clk_out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_sel |-> !clk_out);
endmodule

bind colmod_top colmod_chk chk_i (
  .clk         (core_clk),
  .rst_n       (rst_core_n),
  .row_en      (row_en),
  .col_drive   (col_drive),
  .ctrl_word   (ctrl_word),
  .blink_phase (blink_phase),
  .clk_sel     (clk_sel),
  .clk_out     (clk_out)
);

// File: tb/colmod_top_tb_top.sv
`timescale 1ns/1ps
module colmod_top_tb_top;
  import colmod_pkg::*;

  localparam int HALF = 40;

  logic        int_clk = 1'b0;
  logic        ext_clk = 1'b0;
  logic        clk_sel = 1'b1;
  logic        rst_n   = 1'b0;
  logic        int_run = 1'b1;
  logic        ext_mode = 1'b0;
  logic [63:0] chars = '0;
  logic [7:0]  flash = '0;
  logic [4:0]  ctrl  = '0;
  logic [27:0] rom_code;
  logic [15:0] udc_addr;
  logic [2:0]  glyph_row;
  logic [19:0] rom_pat, udc_pat;
  logic [13:0] row_en;
  logic [19:0] col;
  logic        clk_out;

  int vectors = 0;
  int fails   = 0;
  int m_tick, m_slot, m_cnt, m_edges;
  logic m_phase;

  colmod_top #(.HALF_PERIOD(HALF)) dut_i (
    .int_clk      (int_clk),
    .ext_clk      (ext_clk),
    .clk_sel      (clk_sel),
    .rst_n        (rst_n),
    .char_entries (chars),
    .flash_bits   (flash),
    .ctrl_word    (ctrl),
    .rom_code     (rom_code),
    .udc_addr     (udc_addr),
    .glyph_row    (glyph_row),
    .rom_pattern  (rom_pat),
    .udc_pattern  (udc_pat),
    .row_en       (row_en),
    .col_drive    (col),
    .clk_out      (clk_out)
  );

  always #2.5 int_clk = int_run ? ~int_clk : 1'b0;

  function automatic logic [4:0] rom_fn(input logic [6:0] c, input logic [2:0] r);
    return 5'((c * 3 + r * 11 + 5) ^ (c >> 2));
  endfunction

  function automatic logic [4:0] udc_fn(input logic [3:0] a, input logic [2:0] r);
    return 5'(a * 9 + r * 7 + 3) ^ 5'h15;
  endfunction

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      rom_pat[l*5 +: 5] = rom_fn(rom_code[l*7 +: 7], glyph_row);
      udc_pat[l*5 +: 5] = udc_fn(udc_addr[l*4 +: 4], glyph_row);
    end
  end

  // independent scan model, advancing from the third edge after release
  always @(posedge int_clk) begin
    if (!ext_mode) begin
      if (!rst_n) begin
        m_edges = 0; m_tick = 0; m_slot = 0; m_cnt = 0; m_phase = 1'b1;
      end else if (m_edges < 2) begin
        m_edges++;
      end else begin
        if (m_tick == 8) begin
          m_tick = 0;
          m_slot = (m_slot == 13) ? 0 : m_slot + 1;
        end else m_tick++;
        if (m_cnt == HALF - 1) begin
          m_cnt = 0;
          m_phase = !m_phase;
        end else m_cnt++;
      end
    end
  end

  function automatic logic [19:0] exp_col();
    logic [19:0] r;
    int on, code, d;
    logic [7:0] e;
    logic [4:0] p;
    r = '0;
    code = int'(ctrl[2:0]);
    on = (code == 0) ? 8 : 7 - code;
    if (m_tick == 0 || m_tick > on) return '0;
    if (ctrl[4] && !m_phase) return '0;
    for (int l = 0; l < 4; l++) begin
      d = (m_slot % 2) * 4 + l;
      e = chars[d*8 +: 8];
      p = e[7] ? udc_fn(e[3:0], 3'(m_slot / 2)) : rom_fn(e[6:0], 3'(m_slot / 2));
      if (ctrl[3] && flash[d] && !m_phase) p = '0;
      r[l*5 +: 5] = p;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic check_cycle(input string tag);
    check("R2 row_en", 32'(row_en), 32'(14'(1) << m_slot));
    if (m_tick == 0) check("R3 blank", 32'(col), 32'(exp_col()));
    else             check(tag, 32'(col), 32'(exp_col()));
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge int_clk);
      check_cycle(tag);
    end
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1; #5;
    ext_clk = 1'b0; #5;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    chars = {8'h41, 8'h85, 8'h30, 8'h8F, 8'h7E, 8'h80, 8'h20, 8'h5A};
    flash = 8'hFF;
    ctrl  = 5'd0;
    repeat (4) @(negedge int_clk);
    // R1 reset state
    check("R1 row_en", 32'(row_en), 32'h1);
    check("R1 col", 32'(col), 32'h0);
    rst_n = 1'b1;
    @(negedge int_clk);
    check("R1 col pre-scan", 32'(col), 32'h0);
    check("R1 row_en pre-scan", 32'(row_en), 32'h1);
    // R5 / R7 flash bits ignored while flash is disabled
    run(300, "R5 R7 fetch");
    // R4 brightness sweep
    for (int c = 0; c < 8; c++) begin
      ctrl = 5'(c);
      run(40, "R4 duty");
    end
    // R7 per-digit flash, across R6 toggle edges
    ctrl  = 5'b01000;
    flash = 8'hA5;
    run(240, "R7 R6 flash");
    // R8 blink
    ctrl = 5'b10010;
    run(240, "R8 R6 blink");
    // random mix
    for (int k = 0; k < 120; k++) begin
      chars = {$urandom, $urandom};
      flash = 8'($urandom);
      ctrl  = 5'($urandom);
      run(25, "R5 R6 random");
    end
    // R9 clock output follows internal clock
    @(posedge int_clk); #1;
    check("R9 clk_out high", 32'(clk_out), 32'h1);
    @(negedge int_clk);
    check("R9 clk_out low", 32'(clk_out), 32'h0);
    // R9 external clock drives the block
    ext_mode = 1'b1;
    int_run  = 1'b0;
    clk_sel  = 1'b0;
    rst_n    = 1'b0;
    #10;
    rst_n = 1'b1;
    #5;
    repeat (10) ext_pulse();
    check("R9 ext row_en before step", 32'(row_en), 32'h1);
    check("R9 clk_out idle", 32'(clk_out), 32'h0);
    ext_pulse();
    check("R9 ext row_en after step", 32'(row_en), 32'h2);
    // back to the internal clock
    rst_n    = 1'b0;
    clk_sel  = 1'b1;
    ext_mode = 1'b0;
    int_run  = 1'b1;
    ctrl     = 5'd0;
    repeat (3) @(negedge int_clk);
    check("R1 row_en re-reset", 32'(row_en), 32'h1);
    rst_n = 1'b1;
    run(200, "R5 resume");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule